// File: doc/BRIEF.md
# Banked GPR Access Unit

This unit turns a general-purpose register operand into a storage access and carries out that access on the register bank that is currently selected. A 2-bit bank code picks one of three local banks or the global bank. Each local bank holds sixteen 16-bit registers in flip-flops. The global bank lives in an internal dual-port RAM at a byte base given by a 12-bit context pointer. One operand can be written in four forms: a short 4-bit register number, a short 2-bit register number, an 8-bit register-window address, or an indirect-pointer fetch. Each form can be used as a word, a byte or a single bit.

In word and bit modes the register number is doubled to form a byte offset. In byte mode the register number is already a byte offset. Within a word, byte order is little-endian. For the global bank the byte offset is added to the context pointer. The resulting physical address must lie inside the RAM window. If it does not, the unit flags an error and performs no access. An 8-bit address outside the top sixteen window entries is reported as not being a register.

Top module: `gpr_access_unit`

## Requirements
- R1: After reset `rd_valid`, `rd_data`, `not_gpr` and `win_err` are 0, and every local-bank register reads as 0000h.
- R2: `bank_sel` codes 1, 2 and 3 select local banks 0, 1 and 2, and code 0 selects the global bank. A short 4-bit operand (`op_kind`=0) in word mode (`acc_mode`=0) reaches registers 0 to 15 through `addr[3:0]`. Each local bank holds its own contents.
- R3: A short 2-bit operand (`op_kind`=1) uses only `addr[1:0]` as the register number, and `addr[7:2]` has no effect.
- R4: In byte mode (`acc_mode`=1) the operand number is the byte offset. Offset n lies in register n/2, with an even offset selecting bits 7:0 and an odd offset selecting bits 15:8. A byte write stores `wr_data[7:0]` into that lane only. A byte read returns the byte zero-extended.
- R5: A register-window operand (`op_kind`=2) with `addr[7:4]`=Fh addresses the register given by `addr[3:0]`, exactly as a short 4-bit operand does.
- R6: A register-window operand with `addr[7:4]` below Fh raises `not_gpr` in the same cycle. It writes nothing, and `rd_valid` stays 0 for it.
- R7: In bit mode (`acc_mode`=2) the word is chosen as in word mode and `bit_pos` picks the bit. A bit write sets that bit to `wr_data[0]` and leaves the other 15 bits unchanged. A bit read returns the bit in `rd_data[0]`, with bits 15:1 at 0.
- R8: An indirect-pointer operand (`op_kind`=3) is always accessed as a full word with the register number from `addr[3:0]`, whatever `acc_mode` requests.
- R9: With the global bank selected, `ram_addr` equals `cp` plus the byte offset, modulo 4096, in the same cycle as `req`. Otherwise `ram_addr` is 0.
- R10: A global access whose physical address lies outside E00h..FFFh raises `win_err` in the same cycle, writes nothing, and gives no `rd_valid`.
- R11: A read request produces `rd_valid`=1 and its data in the cycle after the request edge, for both local and global banks, and `rd_valid` returns to 0 after one cycle. A write takes effect at its request edge, so a read in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| bank_sel | input | 2 | 0 = global bank, 1..3 = local banks 0..2 |
| cp | input | 12 | Context pointer, byte base of the global bank |
| op_kind | input | 2 | 0 short 4-bit, 1 short 2-bit, 2 register window, 3 indirect pointer |
| addr | input | 8 | Operand address field |
| acc_mode | input | 2 | 0 word, 1 byte, 2 bit (3 treated as word) |
| bit_pos | input | 4 | Bit index for bit mode |
| wr_data | input | 16 | Write data (byte: bits 7:0, bit: bit 0) |
| rd_data | output | 16 | Formatted read data, 0 when not valid |
| rd_valid | output | 1 | Read data valid |
| ram_addr | output | 12 | Physical global-bank byte address |
| not_gpr | output | 1 | Register-window address is not a register |
| win_err | output | 1 | Global address outside the RAM window |

## Verification
`not_gpr`, `win_err` and `ram_addr` are combinational from the request, so the bench samples them one time unit after it drives the inputs on the falling edge, which is before the capturing rising edge. `rd_valid` and `rd_data` are registered and are due one rising edge after the request. The bench therefore samples them at the falling edge that follows that edge, and drops `req` at the same moment. An extra idle cycle after a read confirms that `rd_valid` has fallen again. Write effects are always observed through a later read, so no check depends on when storage is updated internally.

// File: rtl/gpr_pkg.sv
// Shared encodings for the banked GPR access unit.
// Assumes a 16-bit register word and sixteen registers per bank.
package gpr_pkg;
    localparam int DW        = 16;
    localparam int NREG      = 16;
    localparam int RIDX_W    = $clog2(NREG);
    localparam int NUM_LOCAL = 3;
    localparam int LB_W      = $clog2(NUM_LOCAL);

    typedef enum logic [1:0] {
        OP_SHORT4 = 2'd0,
        OP_SHORT2 = 2'd1,
        OP_REG8   = 2'd2,
        OP_INDIR  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        MODE_WORD = 2'd0,
        MODE_BYTE = 2'd1,
        MODE_BIT  = 2'd2,
        MODE_RSVD = 2'd3
    } acc_mode_e;
endpackage

// File: rtl/gpr_addr_decode.sv
// Operand decoder: turns an operand form and access mode into a register
// index, byte lane and, for the global bank, a physical byte address plus
// a RAM word index. Purely combinational. Assumes the RAM window starts at
// an even byte address.
module gpr_addr_decode
    import gpr_pkg::*;
#(
    parameter logic [11:0] WIN_BASE  = 12'hE00,
    parameter int          RAM_WORDS = 256,
    localparam int         RAM_AW    = $clog2(RAM_WORDS)
) (
    input  logic [1:0]        op_kind,
    input  logic [7:0]        addr,
    input  logic [1:0]        acc_mode,
    input  logic [1:0]        bank_sel,
    input  logic [11:0]       cp,
    output logic              not_gpr,
    output acc_mode_e         eff_mode,
    output logic [RIDX_W-1:0] reg_idx,
    output logic              lane,
    output logic              is_global,
    output logic [11:0]       phys_addr,
    output logic              in_window,
    output logic [RAM_AW-1:0] ram_word
);
    localparam logic [12:0] WIN_END = 13'(WIN_BASE) + 13'(2 * RAM_WORDS);

    op_kind_e    kind;
    logic [3:0]  nib;
    logic [4:0]  byte_off;
    logic [11:0] rel;

    assign kind = op_kind_e'(op_kind);

    // Pick the register number and the effective access mode.
    always_comb begin
        nib = (kind == OP_SHORT2) ? {2'b00, addr[1:0]} : addr[3:0];
        if (kind == OP_INDIR || acc_mode == MODE_RSVD)
            eff_mode = MODE_WORD;
        else
            eff_mode = acc_mode_e'(acc_mode);
    end

    assign not_gpr   = (kind == OP_REG8) && (addr[7:4] != 4'hF);
    assign byte_off  = (eff_mode == MODE_BYTE) ? {1'b0, nib} : {nib, 1'b0};
    assign reg_idx   = byte_off[4:1];
    assign is_global = (bank_sel == 2'd0);

    // Global address: context pointer plus byte offset, wrapping at 4 KB.
    always_comb begin
        phys_addr = cp + {7'd0, byte_off};
        in_window = (phys_addr >= WIN_BASE) && ({1'b0, phys_addr} < WIN_END);
        rel       = phys_addr - WIN_BASE;
        ram_word  = RAM_AW'(rel >> 1);
        lane      = is_global ? phys_addr[0] : byte_off[0];
    end
endmodule

// File: rtl/gpr_lane_unit.sv
// Lane logic: builds the write mask and write value for word, byte and bit
// writes, and formats a stored word into read data for the same modes.
// Combinational; assumes a 16-bit word made of two little-endian bytes.
module gpr_lane_unit
    import gpr_pkg::*;
(
    input  acc_mode_e         w_mode,
    input  logic              w_lane,
    input  logic [3:0]        w_bit,
    input  logic [DW-1:0]     w_data,
    output logic [DW-1:0]     w_mask,
    output logic [DW-1:0]     w_val,
    input  acc_mode_e         r_mode,
    input  logic              r_lane,
    input  logic [3:0]        r_bit,
    input  logic [DW-1:0]     r_word,
    output logic [DW-1:0]     r_data
);
    localparam int NLANE = DW / 8;

    logic [DW-1:0] byte_mask;

    // One mask byte per lane: set for word writes or for the addressed byte.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign byte_mask[l*8 +: 8] =
            ((w_mode == MODE_WORD) || (w_mode == MODE_BYTE && int'(w_lane) == l))
            ? 8'hFF : 8'h00;
    end

    // Select mask and replicated value by mode.
    always_comb begin
        case (w_mode)
            MODE_BIT: begin
                w_mask = DW'(1) << w_bit;
                w_val  = {DW{w_data[0]}};
            end
            MODE_BYTE: begin
                w_mask = byte_mask;
                w_val  = {w_data[7:0], w_data[7:0]};
            end
            default: begin
                w_mask = byte_mask;
                w_val  = w_data;
            end
        endcase
    end

    // Format read data: whole word, zero-extended byte, or single bit.
    always_comb begin
        case (r_mode)
            MODE_BYTE: r_data = r_lane ? {8'h00, r_word[15:8]} : {8'h00, r_word[7:0]};
            MODE_BIT:  r_data = {{(DW-1){1'b0}}, r_word[r_bit]};
            default:   r_data = r_word;
        endcase
    end

    // R7
    always_comb begin
        if (w_mode == MODE_BIT) begin
            bit_mask_single_chk: assert ($countones(w_mask) == 1)
                else $error("bit-mode write mask is not a single bit");
        end
    end
endmodule

// File: rtl/gpr_local_banks.sv
// Local register banks held in flip-flops, with masked writes and a
// registered read port. Assumes at most one of write or read per cycle.
module gpr_local_banks
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [LB_W-1:0]   bank_idx,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [DW-1:0]     wmask,
    input  logic [DW-1:0]     wval,
    output logic [DW-1:0]     rd_word
);
    logic [DW-1:0] regs [NUM_LOCAL][NREG];

    // Storage update: clear on reset, otherwise merge masked write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_LOCAL; b++)
                for (int r = 0; r < NREG; r++)
                    regs[b][r] <= '0;
        end else if (we) begin
            regs[bank_idx][reg_idx] <= (regs[bank_idx][reg_idx] & ~wmask) | (wval & wmask);
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_word <= '0;
        else if (re) rd_word <= regs[bank_idx][reg_idx];
    end

    // Checker state: remember the last write to test lane isolation.
    logic              chk_we;
    logic [LB_W-1:0]   chk_bank;
    logic [RIDX_W-1:0] chk_idx;
    logic [DW-1:0]     chk_mask;
    logic [DW-1:0]     chk_old;

    // Capture the target and the old contents of each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_we <= 1'b0; chk_bank <= '0; chk_idx <= '0; chk_mask <= '0; chk_old <= '0;
        end else begin
            chk_we   <= we;
            chk_bank <= bank_idx;
            chk_idx  <= reg_idx;
            chk_mask <= wmask;
            chk_old  <= regs[bank_idx][reg_idx];
        end
    end

    // R4
    lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_we |-> (((regs[chk_bank][chk_idx] ^ chk_old) & ~chk_mask) == '0))
        else $error("local write changed bits outside its mask");
endmodule

// File: rtl/gpr_dpram.sv
// Internal dual-port RAM for the global bank: port A writes with a bit
// mask, port B reads with one clock of latency. No reset of contents.
module gpr_dpram
    import gpr_pkg::*;
#(
    parameter  int WORDS = 256,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_mask,
    input  logic [DW-1:0] a_val,
    input  logic          b_re,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_data
);
    logic [DW-1:0] mem [WORDS];

    // Port A: masked write.
    always_ff @(posedge clk) begin
        if (a_we)
            mem[a_addr] <= (mem[a_addr] & ~a_mask) | (a_val & a_mask);
    end

    // Port B: registered read.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_data <= '0;
        else if (b_re) b_data <= mem[b_addr];
    end

    // R11
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_we && b_re))
        else $error("RAM write and read requested in one cycle");
endmodule

// File: rtl/gpr_access_unit.sv
// Top of the banked GPR access unit. Decodes the operand, enforces the
// not-a-register and RAM-window rules, steers the access to a local bank
// or the global RAM, and formats read data one clock later. Assumes req
// carries at most one read or one write per cycle.
module gpr_access_unit
    import gpr_pkg::*;
#(
    parameter logic [11:0] WIN_BASE  = 12'hE00,
    parameter int          RAM_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        wr,
    input  logic [1:0]  bank_sel,
    input  logic [11:0] cp,
    input  logic [1:0]  op_kind,
    input  logic [7:0]  addr,
    input  logic [1:0]  acc_mode,
    input  logic [3:0]  bit_pos,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic [11:0] ram_addr,
    output logic        not_gpr,
    output logic        win_err
);
    localparam int RAM_AW = $clog2(RAM_WORDS);

    logic              dec_not_gpr, dec_global, dec_inwin, dec_lane;
    acc_mode_e         dec_mode;
    logic [RIDX_W-1:0] dec_idx;
    logic [11:0]       dec_phys;
    logic [RAM_AW-1:0] dec_word;
    logic [DW-1:0]     wmask, wval, loc_word, ram_word_q, sel_word, fmt_data;
    logic              acc_ok, loc_we, loc_re, ram_we, ram_re;
    logic [LB_W-1:0]   bank_idx;
    logic              rv_q, rglob_q, rlane_q;
    acc_mode_e         rmode_q;
    logic [3:0]        rbit_q;

    gpr_addr_decode #(.WIN_BASE(WIN_BASE), .RAM_WORDS(RAM_WORDS)) u_dec (
        .op_kind(op_kind), .addr(addr), .acc_mode(acc_mode), .bank_sel(bank_sel),
        .cp(cp), .not_gpr(dec_not_gpr), .eff_mode(dec_mode), .reg_idx(dec_idx),
        .lane(dec_lane), .is_global(dec_global), .phys_addr(dec_phys),
        .in_window(dec_inwin), .ram_word(dec_word)
    );

    // Access qualification and steering.
    always_comb begin
        acc_ok   = req && !dec_not_gpr && (!dec_global || dec_inwin);
        loc_we   = acc_ok && wr && !dec_global;
        loc_re   = acc_ok && !wr && !dec_global;
        ram_we   = acc_ok && wr && dec_global;
        ram_re   = acc_ok && !wr && dec_global;
        bank_idx = LB_W'(bank_sel - 2'd1);
    end

    assign not_gpr  = req && dec_not_gpr;
    assign win_err  = req && dec_global && !dec_not_gpr && !dec_inwin;
    assign ram_addr = (req && dec_global) ? dec_phys : 12'h000;

    gpr_lane_unit u_lane (
        .w_mode(dec_mode), .w_lane(dec_lane), .w_bit(bit_pos), .w_data(wr_data),
        .w_mask(wmask), .w_val(wval),
        .r_mode(rmode_q), .r_lane(rlane_q), .r_bit(rbit_q), .r_word(sel_word),
        .r_data(fmt_data)
    );

    gpr_local_banks u_loc (
        .clk(clk), .rst_n(rst_n), .we(loc_we), .re(loc_re), .bank_idx(bank_idx),
        .reg_idx(dec_idx), .wmask(wmask), .wval(wval), .rd_word(loc_word)
    );

    gpr_dpram #(.WORDS(RAM_WORDS)) u_ram (
        .clk(clk), .rst_n(rst_n), .a_we(ram_we), .a_addr(dec_word), .a_mask(wmask),
        .a_val(wval), .b_re(ram_re), .b_addr(dec_word), .b_data(ram_word_q)
    );

    // Remember how the pending read must be formatted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0; rglob_q <= 1'b0; rlane_q <= 1'b0;
            rmode_q <= MODE_WORD; rbit_q <= '0;
        end else begin
            rv_q    <= loc_re || ram_re;
            rglob_q <= dec_global;
            rlane_q <= dec_lane;
            rmode_q <= dec_mode;
            rbit_q  <= bit_pos;
        end
    end

    assign sel_word = rglob_q ? ram_word_q : loc_word;
    assign rd_valid = rv_q;
    assign rd_data  = rv_q ? fmt_data : '0;

    // R6
    no_read_on_not_gpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_gpr |=> !rd_valid)
        else $error("read data produced for a non-register address");

    // R10
    no_read_on_win_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |=> !rd_valid)
        else $error("read data produced outside the RAM window");

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && !not_gpr && !win_err) |=> rd_valid)
        else $error("read data not valid one clock after request");

    // R9
    ram_addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bank_sel == 2'd0 && !not_gpr && !win_err) |->
            (ram_addr >= WIN_BASE && {1'b0, ram_addr} < 13'(WIN_BASE) + 13'(2 * RAM_WORDS)))
        else $error("accepted global address outside the window");

    // R4
    byte_read_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rmode_q == MODE_BYTE) |-> (rd_data[15:8] == 8'h00))
        else $error("byte read not zero-extended");
endmodule

// File: tb/tb_gpr_access_unit.sv
// Directed bench for the banked GPR access unit.
module tb_gpr_access_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [1:0]  bank_sel = '0, op_kind = '0, acc_mode = '0;
    logic [11:0] cp = '0;
    logic [7:0]  addr = '0;
    logic [3:0]  bit_pos = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid, not_gpr, win_err;
    logic [11:0] ram_addr;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    logic        s_not_gpr, s_win_err, s_valid;
    logic [11:0] s_ram_addr;
    logic [15:0] s_data;

    localparam logic [1:0] K_S4 = 2'd0, K_S2 = 2'd1, K_R8 = 2'd2, K_IND = 2'd3;
    localparam logic [1:0] M_W = 2'd0, M_B = 2'd1, M_BIT = 2'd2;

    gpr_access_unit dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .bank_sel(bank_sel), .cp(cp),
        .op_kind(op_kind), .addr(addr), .acc_mode(acc_mode), .bit_pos(bit_pos),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ram_addr(ram_addr), .not_gpr(not_gpr), .win_err(win_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request cycle; flags sampled before the edge, read data after it.
    task automatic acc(input logic [1:0] bs, input logic [11:0] c, input logic [1:0] k,
                       input logic [7:0] a, input logic [1:0] m, input logic [3:0] bp,
                       input logic w, input logic [15:0] d);
        bank_sel = bs; cp = c; op_kind = k; addr = a; acc_mode = m;
        bit_pos = bp; wr = w; wr_data = d; req = 1'b1;
        #1;
        s_not_gpr = not_gpr; s_win_err = win_err; s_ram_addr = ram_addr;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
        s_valid = rd_valid; s_data = rd_data;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] bs, input logic [11:0] c,
                          input logic [1:0] k, input logic [7:0] a, input logic [1:0] m,
                          input logic [3:0] bp, input logic [15:0] exp);
        acc(bs, c, k, a, m, bp, 1'b0, 16'h0000);
        chk({tag, " valid"}, {15'd0, s_valid}, 16'h0001);
        chk({tag, " data"}, s_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid after reset", {15'd0, rd_valid}, 16'h0000);
        chk("R1 rd_data after reset", rd_data, 16'h0000);
        chk("R1 flags after reset", {14'd0, not_gpr, win_err}, 16'h0000);
        rd_chk("R1 bank1 r0", 2'd1, 12'h0, K_S4, 8'h00, M_W, 4'd0, 16'h0000);
        rd_chk("R1 bank3 r15", 2'd3, 12'h0, K_S4, 8'h0F, M_W, 4'd0, 16'h0000);
    endtask

    task automatic t_words();
        for (int i = 0; i < 16; i++)
            acc(2'd1, 12'h0, K_S4, 8'(i), M_W, 4'd0, 1'b1, 16'hA000 + 16'(i * 16'h0111));
        acc(2'd2, 12'h0, K_S4, 8'h05, M_W, 4'd0, 1'b1, 16'h5555);
        for (int i = 0; i < 16; i++)
            rd_chk("R2 bank1 word", 2'd1, 12'h0, K_S4, 8'(i), M_W, 4'd0,
                   16'hA000 + 16'(i * 16'h0111));
        rd_chk("R2 bank2 r5", 2'd2, 12'h0, K_S4, 8'h05, M_W, 4'd0, 16'h5555);
        rd_chk("R2 bank3 r5 untouched", 2'd3, 12'h0, K_S4, 8'h05, M_W, 4'd0, 16'h0000);
    endtask

    task automatic t_short2();
        acc(2'd1, 12'h0, K_S2, 8'hFE, M_W, 4'd0, 1'b1, 16'h1234);
        rd_chk("R3 short2 lands in r2", 2'd1, 12'h0, K_S4, 8'h02, M_W, 4'd0, 16'h1234);
        rd_chk("R3 r14 unchanged", 2'd1, 12'h0, K_S4, 8'h0E, M_W, 4'd0, 16'hAEEE);
    endtask

    task automatic t_bytes();
        acc(2'd1, 12'h0, K_S4, 8'h03, M_W, 4'd0, 1'b1, 16'h0000);
        acc(2'd1, 12'h0, K_S4, 8'h06, M_B, 4'd0, 1'b1, 16'hFF5A);
        rd_chk("R4 low lane write", 2'd1, 12'h0, K_S4, 8'h03, M_W, 4'd0, 16'h005A);
        acc(2'd1, 12'h0, K_S4, 8'h07, M_B, 4'd0, 1'b1, 16'h00C3);
        rd_chk("R4 high lane write", 2'd1, 12'h0, K_S4, 8'h03, M_W, 4'd0, 16'hC35A);
        rd_chk("R4 odd byte read", 2'd1, 12'h0, K_S4, 8'h07, M_B, 4'd0, 16'h00C3);
        rd_chk("R4 even byte read", 2'd1, 12'h0, K_S4, 8'h06, M_B, 4'd0, 16'h005A);
    endtask

    task automatic t_reg8();
        acc(2'd1, 12'h0, K_R8, 8'hF9, M_W, 4'd0, 1'b1, 16'hBEEF);
        chk("R5 not_gpr low in window", {15'd0, s_not_gpr}, 16'h0000);
        rd_chk("R5 window write to r9", 2'd1, 12'h0, K_S4, 8'h09, M_W, 4'd0, 16'hBEEF);
        rd_chk("R5 window read r9", 2'd1, 12'h0, K_R8, 8'hF9, M_W, 4'd0, 16'hBEEF);
    endtask

    task automatic t_not_gpr();
        acc(2'd1, 12'h0, K_R8, 8'hE9, M_W, 4'd0, 1'b1, 16'h0000);
        chk("R6 not_gpr on write", {15'd0, s_not_gpr}, 16'h0001);
        rd_chk("R6 r9 not written", 2'd1, 12'h0, K_S4, 8'h09, M_W, 4'd0, 16'hBEEF);
        acc(2'd1, 12'h0, K_R8, 8'h39, M_W, 4'd0, 1'b0, 16'h0000);
        chk("R6 not_gpr on read", {15'd0, s_not_gpr}, 16'h0001);
        chk("R6 no rd_valid", {15'd0, s_valid}, 16'h0000);
        chk("R6 rd_data zero", s_data, 16'h0000);
    endtask

    task automatic t_bits();
        acc(2'd1, 12'h0, K_S4, 8'h04, M_W, 4'd0, 1'b1, 16'h0F0F);
        acc(2'd1, 12'h0, K_S4, 8'h04, M_BIT, 4'd15, 1'b1, 16'hFFFF);
        acc(2'd1, 12'h0, K_S4, 8'h04, M_BIT, 4'd0, 1'b1, 16'hFFFE);
        rd_chk("R7 bit writes", 2'd1, 12'h0, K_S4, 8'h04, M_W, 4'd0, 16'h8F0E);
        rd_chk("R7 bit15 read", 2'd1, 12'h0, K_S4, 8'h04, M_BIT, 4'd15, 16'h0001);
        rd_chk("R7 bit4 read", 2'd1, 12'h0, K_S4, 8'h04, M_BIT, 4'd4, 16'h0000);
        rd_chk("R7 bit1 read", 2'd1, 12'h0, K_S4, 8'h04, M_BIT, 4'd1, 16'h0001);
    endtask

    task automatic t_indirect();
        rd_chk("R8 pointer in byte mode", 2'd1, 12'h0, K_IND, 8'h03, M_B, 4'd0, 16'hC35A);
        rd_chk("R8 pointer in bit mode", 2'd1, 12'h0, K_IND, 8'h03, M_BIT, 4'd0, 16'hC35A);
    endtask

    task automatic t_global();
        acc(2'd0, 12'hE20, K_S4, 8'h04, M_W, 4'd0, 1'b1, 16'h7777);
        chk("R9 word address", {4'd0, s_ram_addr}, 16'h0E28);
        chk("R9 in window", {15'd0, s_win_err}, 16'h0000);
        rd_chk("R9 global word", 2'd0, 12'hE20, K_S4, 8'h04, M_W, 4'd0, 16'h7777);
        rd_chk("R9 global odd byte", 2'd0, 12'hE20, K_S4, 8'h09, M_B, 4'd0, 16'h0077);
        chk("R9 byte address", {4'd0, s_ram_addr}, 16'h0E29);
        acc(2'd0, 12'hE20, K_S4, 8'h08, M_B, 4'd0, 1'b1, 16'h0011);
        rd_chk("R9 global byte write", 2'd0, 12'hE20, K_S4, 8'h04, M_W, 4'd0, 16'h7711);
        acc(2'd0, 12'hE20, K_S4, 8'h04, M_BIT, 4'd3, 1'b1, 16'h0001);
        rd_chk("R9 global bit write", 2'd0, 12'hE20, K_S4, 8'h04, M_W, 4'd0, 16'h7719);
        rd_chk("R9 local r4 separate", 2'd1, 12'hE20, K_S4, 8'h04, M_W, 4'd0, 16'h8F0E);
        chk("R9 ram_addr zero for local", {4'd0, s_ram_addr}, 16'h0000);
    endtask

    task automatic t_window();
        acc(2'd0, 12'hFE0, K_S4, 8'h0F, M_W, 4'd0, 1'b1, 16'hABCD);
        chk("R10 top word accepted", {15'd0, s_win_err}, 16'h0000);
        chk("R10 top word address", {4'd0, s_ram_addr}, 16'h0FFE);
        rd_chk("R10 top word read", 2'd0, 12'hFE0, K_S4, 8'h0F, M_W, 4'd0, 16'hABCD);
        acc(2'd0, 12'hFF0, K_S4, 8'h0A, M_W, 4'd0, 1'b1, 16'h1111);
        chk("R10 wrap flagged", {15'd0, s_win_err}, 16'h0001);
        chk("R10 wrap address", {4'd0, s_ram_addr}, 16'h0004);
        acc(2'd0, 12'hD00, K_S4, 8'h00, M_W, 4'd0, 1'b0, 16'h0000);
        chk("R10 below window flagged", {15'd0, s_win_err}, 16'h0001);
        chk("R10 no rd_valid", {15'd0, s_valid}, 16'h0000);
        rd_chk("R10 top word kept", 2'd0, 12'hFE0, K_S4, 8'h0F, M_W, 4'd0, 16'hABCD);
    endtask

    task automatic t_latency();
        rd_chk("R11 read then", 2'd2, 12'h0, K_S4, 8'h05, M_W, 4'd0, 16'h5555);
        idle();
        chk("R11 rd_valid falls", {15'd0, rd_valid}, 16'h0000);
        acc(2'd2, 12'h0, K_S4, 8'h05, M_W, 4'd0, 1'b1, 16'h0BAD);
        chk("R11 no rd_valid on write", {15'd0, s_valid}, 16'h0000);
        rd_chk("R11 back-to-back read", 2'd2, 12'h0, K_S4, 8'h05, M_W, 4'd0, 16'h0BAD);
        acc(2'd0, 12'hE00, K_S4, 8'h00, M_W, 4'd0, 1'b1, 16'h4242);
        rd_chk("R11 global back-to-back", 2'd0, 12'hE00, K_S4, 8'h00, M_W, 4'd0, 16'h4242);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_words();
        t_short2();
        t_bytes();
        t_reg8();
        t_not_gpr();
        t_bits();
        t_indirect();
        t_global();
        t_window();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule